// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block sits behind an SPI memory front end and turns a write command into a committed page update. The front end, which already deserializes the serial stream into bytes, reports the command's start address, then one strobe for each data byte received, and finally the moment chip select is released, together with a flag saying whether the bit counter was on a byte boundary at that moment. Incoming bytes go into a 16-entry page latch. The latch index starts at the low bits of the start address and wraps inside the page, so that long bursts overwrite earlier entries instead of spilling into the next page. A per-entry valid mask records which positions were actually loaded.

When chip select rises cleanly after at least one whole data byte, and the protection unit grants write permission, the block enters a self-timed program cycle. The cycle length is a parameter counted in system clocks. During the cycle the write-in-progress flag is high. The latched bytes are copied into the internal array model one position per clock, and for each one the protection unit is asked whether the target address may be written. New commands, data bytes and array reads are ignored for the whole cycle. When the cycle ends, a one-clock pulse tells the write enable latch to clear. The array model also serves plain byte reads whenever no cycle is running.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, `wip` and `wel_clr` are 0, and every array byte reads back as 8'hFF.
- R2: A command with one data byte, closed by an aligned `cs_rise` while `wr_allow` is 1, stores that byte at the start address, and the neighbouring address is left unchanged.
- R3: The latch index is the low 4 bits of the address and increments after each byte, wrapping from 15 to 0 within the same page. A burst that starts at offset 14 therefore lands at offsets 14, 15, 0, 1, and the following page is not touched.
- R4: When more than 16 bytes are sent, a later byte replaces the earlier one at the same page offset. With 17 bytes sent from offset 0, offset 0 holds the 17th byte.
- R5: A `cs_rise` with `bit_aligned` = 0 abandons the command: `wip` stays 0 and the array is unchanged.
- R6: A `cs_rise` before any complete data byte abandons the command: `wip` stays 0 and the array is unchanged.
- R7: Page positions that received no byte in a command keep their previous array contents after the commit.
- R8: During commit, each loaded position is offered on `prot_qaddr`. The byte is dropped when `prot_block` is 1 for that address, and the other bytes are still written.
- R9: `wip` rises on the clock edge that accepts a committing `cs_rise` and stays high for exactly WR_CYCLES clocks. `wel_clr` is high for one clock, in the first clock after `wip` falls.
- R10: While `wip` is 1, `rd_req` gets no acknowledge and `wr_start`, `byte_vld` and `cs_rise` have no effect on the array or on the cycle.
- R11: A `cs_rise` while `wr_allow` is 0 commits nothing. If `wr_allow` drops after a cycle has started, the cycle still completes and writes its bytes.
- R12: A read with `rd_req` = 1 while idle returns `rd_data` and `rd_ack` = 1 on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Write command decoded; latches `wr_addr` |
| wr_addr | input | ADDR_W | Start address of the write command |
| byte_vld | input | 1 | One complete data byte received |
| byte_data | input | DATA_W | The received data byte |
| cs_rise | input | 1 | Chip select has just been released |
| bit_aligned | input | 1 | Bit counter was on a byte boundary at `cs_rise` |
| wr_allow | input | 1 | Write permission from the protection unit |
| prot_qaddr | output | ADDR_W | Address being committed, sent to the protection unit |
| prot_block | input | 1 | Protection unit forbids writing `prot_qaddr` |
| rd_req | input | 1 | Array read request |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Read data, valid when `rd_ack` is 1 |
| rd_ack | output | 1 | Read serviced on the previous clock |
| wip | output | 1 | Write cycle in progress |
| wel_clr | output | 1 | One-clock request to clear the write enable latch |

## Verification
On every clock, the assertions check the in-page index wrap, that an unaligned or empty close of chip select never starts a cycle, that a running cycle cannot be cut short, that reads get no acknowledge while `wip` is high, and that the latch-clear pulse directly follows the end of `wip`. Only the directed scenarios can show which bytes land at which array addresses: wrap placement, overwrite on wrap, retention of unloaded positions, bytes dropped at protected addresses, and the exact cycle length. Those are all read back through the normal read port.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgwr_state_e;
endpackage

// File: rtl/pgwr_latch.sv
module pgwr_latch #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           load_en,
  input  logic [PAGE_W-1:0]              load_idx,
  input  logic [DATA_W-1:0]              load_data,
  output logic [(1<<PAGE_W)-1:0][DATA_W-1:0] ent_data,
  output logic [(1<<PAGE_W)-1:0]         ent_valid
);
  localparam int PAGE = 1 << PAGE_W;

  for (genvar g = 0; g < PAGE; g++) begin : g_ent
    logic hit;
    assign hit = load_en && (load_idx == PAGE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
      end else if (clear) begin
        ent_valid[g] <= 1'b0;
      end else if (hit) begin
        ent_valid[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_data[g] <= '0;
      end else if (hit) begin
        ent_data[g] <= load_data;
      end
    end
  end
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int WR_CYCLES = 1000,
  parameter int CNT_W     = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done = run && (cnt == LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run && !done) begin
      cnt_en = 1'b1;
      cnt_d  = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '1;
    end else if (rd_en) begin
      rd_data <= cells[rd_addr];
    end
  end
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise,
  input  logic              bit_aligned,
  input  logic              wr_allow,
  output logic [ADDR_W-1:0] prot_qaddr,
  input  logic              prot_block,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack,
  output logic              wip,
  output logic              wel_clr
);
  import pgwr_pkg::*;

  localparam int PAGE  = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE);

  pgwr_state_e       state_q, state_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [PAGE_W-1:0] ptr_q, ptr_d;
  logic              got_q, got_d;
  logic              ctl_en;
  logic              latch_clr, latch_ld, tmr_start, tmr_done;
  logic              wel_clr_d;
  logic [CNT_W-1:0]  tmr_cnt;
  logic [PAGE_W-1:0] cm_idx;
  logic              cm_window;
  logic              arr_we, arr_re;
  logic              rd_ack_d;
  logic [PAGE-1:0][DATA_W-1:0] lat_data;
  logic [PAGE-1:0]   lat_valid;

  // next-state
  always_comb begin
    state_d   = state_q;
    row_d     = row_q;
    ptr_d     = ptr_q;
    got_d     = got_q;
    latch_clr = 1'b0;
    latch_ld  = 1'b0;
    tmr_start = 1'b0;
    wel_clr_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_start) begin
          row_d     = wr_addr[ADDR_W-1:PAGE_W];
          ptr_d     = wr_addr[PAGE_W-1:0];
          got_d     = 1'b0;
          latch_clr = 1'b1;
          state_d   = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (cs_rise) begin
          if (got_q && bit_aligned && wr_allow) begin
            tmr_start = 1'b1;
            state_d   = ST_PROG;
          end else begin
            state_d   = ST_IDLE;
          end
        end else if (byte_vld) begin
          latch_ld = 1'b1;
          ptr_d    = ptr_q + 1'b1;
          got_d    = 1'b1;
        end
      end
      ST_PROG: begin
        if (tmr_done) begin
          wel_clr_d = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctl_en = (state_q != state_d) || latch_ld || latch_clr;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      ptr_q   <= '0;
      got_q   <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      row_q   <= row_d;
      ptr_q   <= ptr_d;
      got_q   <= got_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_clr <= 1'b0;
      rd_ack  <= 1'b0;
    end else begin
      wel_clr <= wel_clr_d;
      rd_ack  <= rd_ack_d;
    end
  end

  assign wip = (state_q == ST_PROG);

  pgwr_latch #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (latch_clr),
    .load_en   (latch_ld),
    .load_idx  (ptr_q),
    .load_data (byte_data),
    .ent_data  (lat_data),
    .ent_valid (lat_valid)
  );

  pgwr_timer #(.WR_CYCLES(WR_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .run   (wip),
    .cnt   (tmr_cnt),
    .done  (tmr_done)
  );

  // commit walk: one page position per clock during the first PAGE clocks
  assign cm_idx     = tmr_cnt[PAGE_W-1:0];
  assign cm_window  = wip && (tmr_cnt < PAGE_CNT);
  assign prot_qaddr = {row_q, cm_idx};
  assign arr_we     = cm_window && lat_valid[cm_idx] && !prot_block;
  assign arr_re     = rd_req && !wip;
  assign rd_ack_d   = arr_re;

  pgwr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (arr_we),
    .wr_addr (prot_qaddr),
    .wr_data (lat_data[cm_idx]),
    .rd_en   (arr_re),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // R3: in-page index wraps to the page start
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && !cs_rise && byte_vld && ptr_q == PAGE_W'(PAGE-1)) |=> (ptr_q == '0))
    else $error("p_wrap_r3");

  // R5: unaligned close never starts a cycle
  p_abort_unaligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && cs_rise && !bit_aligned) |=> !wip)
    else $error("p_abort_unaligned_r5");

  // R6: close without a whole byte never starts a cycle
  p_abort_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && cs_rise && !got_q) |=> (state_q == ST_IDLE))
    else $error("p_abort_empty_r6");

  // R11: a running cycle is not cut short
  p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && !tmr_done) |=> wip)
    else $error("p_hold_busy_r11");

  // R10: no read acknowledge while busy
  p_rd_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> !rd_ack)
    else $error("p_rd_blocked_r10");

  // R9: latch-clear pulse follows the end of the cycle
  p_wel_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> (!wip && $past(wip)))
    else $error("p_wel_clr_r9");
endmodule

// File: tb/test_pgwr_commit.sv
module test_pgwr_commit;
  localparam int WR_CYC = 40;

  logic       clk;
  logic       rst_n;
  logic       wr_start, byte_vld, cs_rise, bit_aligned, wr_allow;
  logic [7:0] wr_addr, byte_data, rd_addr, rd_data, prot_qaddr;
  logic       prot_block, rd_req, rd_ack, wip, wel_clr;
  logic       prot_on;
  logic [7:0] prot_lo;
  int         n_chk, n_bad;
  bit         finished;

  pgwr_commit #(.ADDR_W(8), .DATA_W(8), .PAGE_W(4), .WR_CYCLES(WR_CYC)) i_pgwr_commit (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .bit_aligned(bit_aligned), .wr_allow(wr_allow), .prot_qaddr(prot_qaddr),
    .prot_block(prot_block), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_ack(rd_ack), .wip(wip), .wel_clr(wel_clr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // protection unit model: block addresses at or above prot_lo when enabled
  always_comb prot_block = prot_on && (prot_qaddr >= prot_lo);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmd_start(input logic [7:0] a);
    wr_start = 1'b1; wr_addr = a;
    @(negedge clk);
    wr_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    byte_vld = 1'b1; byte_data = d;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic cs_up(input logic aligned);
    cs_rise = 1'b1; bit_aligned = aligned;
    @(negedge clk);
    cs_rise = 1'b0; bit_aligned = 1'b1;
  endtask

  task automatic wait_idle();
    while (wip) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic ack);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    d = rd_data; ack = rd_ack;
    rd_req = 1'b0;
  endtask

  task automatic chk_mem(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic       k;
    rd(a, d, k);
    chk({tag, " ack"}, {31'd0, k}, 32'd1);
    chk(tag, {24'd0, d}, {24'd0, exp});
  endtask

  task automatic t_reset();
    chk("R1 wip after reset", {31'd0, wip}, 32'd0);
    chk("R1 wel_clr after reset", {31'd0, wel_clr}, 32'd0);
    chk_mem("R1 R12 erased 00", 8'h00, 8'hFF);
    chk_mem("R1 R12 erased C5", 8'hC5, 8'hFF);
  endtask

  task automatic t_byte_and_timing();
    int n;
    cmd_start(8'h13);
    send_byte(8'hA5);
    cs_up(1'b1);
    n = 0;
    while (wip) begin
      n++;
      @(negedge clk);
    end
    chk("R9 wip length", n, WR_CYC);
    chk("R9 wel_clr after wip", {31'd0, wel_clr}, 32'd1);
    @(negedge clk);
    chk("R9 wel_clr one clock", {31'd0, wel_clr}, 32'd0);
    chk_mem("R2 byte written", 8'h13, 8'hA5);
    chk_mem("R2 neighbour kept", 8'h14, 8'hFF);
  endtask

  task automatic t_wrap();
    cmd_start(8'h4E);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    cs_up(1'b1);
    wait_idle();
    chk_mem("R3 offset E", 8'h4E, 8'h11);
    chk_mem("R3 offset F", 8'h4F, 8'h22);
    chk_mem("R3 wrapped 0", 8'h40, 8'h33);
    chk_mem("R3 wrapped 1", 8'h41, 8'h44);
    chk_mem("R3 next page untouched", 8'h50, 8'hFF);
  endtask

  task automatic t_overwrite();
    cmd_start(8'h60);
    for (int i = 0; i < 17; i++) send_byte(8'h80 + 8'(i));
    cs_up(1'b1);
    wait_idle();
    chk_mem("R4 overwritten offset 0", 8'h60, 8'h90);
    chk_mem("R4 offset 1", 8'h61, 8'h81);
    chk_mem("R4 offset F", 8'h6F, 8'h8F);
  endtask

  task automatic t_retain();
    cmd_start(8'h65);
    send_byte(8'hEE);
    cs_up(1'b1);
    wait_idle();
    chk_mem("R7 loaded position", 8'h65, 8'hEE);
    chk_mem("R7 unloaded below", 8'h64, 8'h84);
    chk_mem("R7 unloaded above", 8'h66, 8'h86);
  endtask

  task automatic t_misalign();
    cmd_start(8'h30);
    send_byte(8'h5A);
    cs_up(1'b0);
    chk("R5 no cycle", {31'd0, wip}, 32'd0);
    @(negedge clk);
    chk_mem("R5 array unchanged", 8'h30, 8'hFF);
  endtask

  task automatic t_empty();
    cmd_start(8'h31);
    cs_up(1'b1);
    chk("R6 no cycle", {31'd0, wip}, 32'd0);
    @(negedge clk);
    chk_mem("R6 array unchanged", 8'h31, 8'hFF);
  endtask

  task automatic t_protect();
    prot_on = 1'b1; prot_lo = 8'hC2;
    cmd_start(8'hC0);
    send_byte(8'h10); send_byte(8'h20); send_byte(8'h30); send_byte(8'h40);
    cs_up(1'b1);
    wait_idle();
    prot_on = 1'b0;
    chk_mem("R8 open C0", 8'hC0, 8'h10);
    chk_mem("R8 open C1", 8'hC1, 8'h20);
    chk_mem("R8 dropped C2", 8'hC2, 8'hFF);
    chk_mem("R8 dropped C3", 8'hC3, 8'hFF);
  endtask

  task automatic t_busy();
    logic [7:0] d;
    logic       k;
    cmd_start(8'h70);
    send_byte(8'h77);
    cs_up(1'b1);
    rd(8'h70, d, k);
    chk("R10 no read ack while busy", {31'd0, k}, 32'd0);
    cmd_start(8'h71);
    send_byte(8'h99);
    cs_up(1'b1);
    chk("R10 still busy", {31'd0, wip}, 32'd1);
    wait_idle();
    chk_mem("R10 busy write ignored", 8'h71, 8'hFF);
    chk_mem("R10 cycle byte written", 8'h70, 8'h77);
  endtask

  task automatic t_allow();
    wr_allow = 1'b0;
    cmd_start(8'h80);
    send_byte(8'h12);
    cs_up(1'b1);
    chk("R11 denied no cycle", {31'd0, wip}, 32'd0);
    @(negedge clk);
    chk_mem("R11 denied unchanged", 8'h80, 8'hFF);
    wr_allow = 1'b1;
    cmd_start(8'h81);
    send_byte(8'h34);
    cs_up(1'b1);
    wr_allow = 1'b0;
    @(negedge clk);
    chk("R11 cycle continues", {31'd0, wip}, 32'd1);
    wait_idle();
    wr_allow = 1'b1;
    chk_mem("R11 completed write", 8'h81, 8'h34);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    wr_start = 0; byte_vld = 0; cs_rise = 0; bit_aligned = 1; wr_allow = 1;
    wr_addr = 0; byte_data = 0; rd_req = 0; rd_addr = 0;
    prot_on = 0; prot_lo = 8'hFF;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_and_timing();
    t_wrap();
    t_overwrite();
    t_retain();
    t_misalign();
    t_empty();
    t_protect();
    t_busy();
    t_allow();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule